// File: doc/BRIEF.md
# Bulk Endpoint Instruction Download Packer

This block takes byte streams from several bulk OUT endpoints and turns them into 24-bit instruction writes on a single program-memory write port. Every endpoint carries its own base address and its own write offset. Software sets the base through a plain register-write strobe before code streams on that endpoint. Each four bytes that arrive on an endpoint form one group. The bytes come most significant first. The last byte of the group is padding that should be zero, and the block drops it. The first three bytes become one instruction word, written at base plus offset. The offset then advances by one word.

Several endpoints may stream at the same time, each into its own address range. A round-robin arbiter picks one completed word per cycle for the memory port. The memory port always accepts a write. Each byte input uses a valid/ready handshake, and a byte moves on a cycle where both are high. An endpoint drops ready while its finished word waits for the memory port, and also in the cycle its base register is written. The sender must hold valid and data steady until the byte is taken.

Top module: `dl_packer_top`

## Requirements
- R1: After reset, `mem_we` is 0, `lsb_err` is all zeros and every `s_ready` bit is 1.
- R2: On endpoint i, byte lane `s_data[8*i+7:8*i]`, the first byte of a group lands in bits 23:16 of the word, the second in bits 15:8 and the third in bits 7:0. The fourth byte is not written. For example, the bytes 0x40,0x00,0x00,0x00 give the word 0x400000.
- R3: A pulse on `cfg_we` with endpoint index `cfg_ep` (0-based) does four things to that endpoint: it loads `cfg_base`, clears the offset to zero, discards any partly collected group and discards any word still waiting. In that cycle the endpoint's `s_ready` is 0.
- R4: The first word after a base write goes to the base address. Each later word on that endpoint goes to the previous address plus one, with wrap-around at the address width.
- R5: Each endpoint's address sequence is independent of traffic on the other endpoints.
- R6: At most one memory write happens per cycle. When several endpoints have words waiting, grants go in increasing index order, starting from the endpoint just after the last one granted. After reset, endpoint 0 is first.
- R7: An endpoint's `s_ready` is 0 from the cycle after its group completes until its word has been written.
- R8: If the fourth byte of a group is nonzero, that endpoint's `lsb_err` bit becomes 1 and stays 1 until reset. The word is still written.
- R9: A group whose fourth byte is zero does not set `lsb_err`.
- R10: For an endpoint with no competing request, `mem_we` goes high for its word in the cycle right after the clock edge that took the fourth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base address write strobe |
| cfg_ep | input | 2 | Endpoint index for the base write |
| cfg_base | input | 16 | Base address value |
| s_valid | input | 3 | Byte valid, one bit per endpoint |
| s_data | input | 24 | Byte lanes, endpoint i in bits 8i+7:8i |
| s_ready | output | 3 | Byte ready, one bit per endpoint |
| mem_we | output | 1 | Program memory write enable |
| mem_addr | output | 16 | Program memory word address |
| mem_wdata | output | 24 | Instruction word |
| lsb_err | output | 3 | Sticky nonzero padding-byte flag per endpoint |

## Verification
The main collision is group completion on several endpoints at the same clock edge. Arbitration then runs into back-pressure, because each waiting endpoint holds ready low until its turn comes. The bench starts two and then three endpoints in lockstep. It judges the order, addresses and cycle spacing of the memory writes, and it samples the ready vector in the cycles where the words are still waiting. It also checks a base write that lands on an endpoint holding a partial group. The ready bit of that endpoint must drop, and the bytes already collected must never reach memory.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int DL_BYTE_W = 8;
  localparam int DL_GROUP  = 4;
  localparam int DL_WORD_W = DL_BYTE_W * (DL_GROUP - 1);
  localparam int DL_CNT_W  = $clog2(DL_GROUP);
endpackage

// File: rtl/dl_rr_arbiter.sv
module dl_rr_arbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] gnt_idx;
  logic          found;
  int            idx;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    idx     = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (found) last_q <= gnt_idx;
  end

  assert_onehot_gnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_gnt_has_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/dl_ep_packer.sv
module dl_ep_packer
  import dl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic                 byte_valid,
  input  logic [DL_BYTE_W-1:0] byte_data,
  output logic                 byte_ready,
  output logic                 word_valid,
  output logic [DL_WORD_W-1:0] word_data,
  output logic [ADDR_W-1:0]    word_addr,
  input  logic                 grant_i,
  output logic                 err_o
);
  logic [ADDR_W-1:0]    base_q, off_q;
  logic [DL_CNT_W-1:0]  cnt_q;
  logic [DL_WORD_W-1:0] sh_q, word_q;
  logic                 valid_q, err_q;

  assign byte_ready = !valid_q && !clr_i;
  assign word_valid = valid_q;
  assign word_data  = word_q;
  assign word_addr  = base_q + off_q;
  assign err_o      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      off_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (clr_i) begin
      base_q  <= base_i;
      off_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (grant_i) begin
        valid_q <= 1'b0;
        off_q   <= off_q + 1'b1;
      end
      if (byte_valid && byte_ready) begin
        if (cnt_q == DL_CNT_W'(DL_GROUP - 1)) begin
          word_q  <= sh_q;
          valid_q <= 1'b1;
          cnt_q   <= '0;
          if (byte_data != '0) err_q <= 1'b1;
        end else begin
          sh_q  <= {sh_q[DL_WORD_W-DL_BYTE_W-1:0], byte_data};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && !clr_i) |=> (off_q == $past(off_q) + 1'b1));
  assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !grant_i && !clr_i) |=> (valid_q && $stable(word_q) && !byte_ready));
endmodule

// File: rtl/dl_packer_top.sv
module dl_packer_top
  import dl_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int ADDR_W = 16,
  localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [EP_W-1:0]             cfg_ep,
  input  logic [ADDR_W-1:0]           cfg_base,
  input  logic [NUM_EP-1:0]           s_valid,
  input  logic [NUM_EP*DL_BYTE_W-1:0] s_data,
  output logic [NUM_EP-1:0]           s_ready,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [DL_WORD_W-1:0]        mem_wdata,
  output logic [NUM_EP-1:0]           lsb_err
);
  logic [NUM_EP-1:0]    req, gnt;
  logic [ADDR_W-1:0]    ep_addr [NUM_EP];
  logic [DL_WORD_W-1:0] ep_word [NUM_EP];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic clr;
    assign clr = cfg_we && (cfg_ep == EP_W'(i));
    dl_ep_packer #(.ADDR_W(ADDR_W)) u_pk (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .base_i     (cfg_base),
      .byte_valid (s_valid[i]),
      .byte_data  (s_data[i*DL_BYTE_W +: DL_BYTE_W]),
      .byte_ready (s_ready[i]),
      .word_valid (req[i]),
      .word_data  (ep_word[i]),
      .word_addr  (ep_addr[i]),
      .grant_i    (gnt[i]),
      .err_o      (lsb_err[i])
    );
  end

  dl_rr_arbiter #(.N(NUM_EP)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  always_comb begin
    mem_we    = |gnt;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (gnt[i]) begin
        mem_addr  = mem_addr  | ep_addr[i];
        mem_wdata = mem_wdata | ep_word[i];
      end
    end
  end

  assert_pending_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> mem_we);
endmodule

// File: tb/sim_dl_packer_top.sv
module sim_dl_packer_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_ep = 0;
  logic [15:0] cfg_base = 0;
  logic [2:0]  s_valid = 0;
  logic [23:0] s_data = 0;
  logic [2:0]  s_ready;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [2:0]  lsb_err;

  int checks = 0, errors = 0, cyc = 0, log_n = 0;
  logic [15:0] log_addr [64];
  logic [23:0] log_data [64];
  int          log_cyc  [64];
  int          done_cyc [3];

  always #5 clk = ~clk;

  dl_packer_top u0 (.*);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && mem_we && log_n < 64) begin
      log_addr[log_n] = mem_addr;
      log_data[log_n] = mem_wdata;
      log_cyc[log_n]  = cyc;
      log_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_base(input int ep, input logic [15:0] b);
    @(negedge clk);
    cfg_we = 1; cfg_ep = 2'(ep); cfg_base = b;
    #1 chk("R3 ready low during base write", 32'(s_ready[ep]), 0);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_byte(input int ep, input logic [7:0] b);
    @(negedge clk);
    s_valid[ep] = 1; s_data[ep*8 +: 8] = b;
    #1;
    while (!s_ready[ep]) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_group(input int ep, input logic [31:0] w);
    for (int k = 0; k < 4; k++) send_byte(ep, w[31-8*k -: 8]);
    @(negedge clk);
    s_valid[ep] = 0;
    done_cyc[ep] = cyc;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_log(input string tag, input int i, input logic [15:0] a, input logic [23:0] d);
    chk({tag, " addr"}, 32'(log_addr[i]), 32'(a));
    chk({tag, " data"}, 32'(log_data[i]), 32'(d));
  endtask

  task automatic t_reset();
    chk("R1 mem_we", 32'(mem_we), 0);
    chk("R1 lsb_err", 32'(lsb_err), 0);
    chk("R1 s_ready", 32'(s_ready), 32'h7);
  endtask

  task automatic t_pack();
    set_base(0, 16'h0100);
    log_n = 0;
    send_group(0, 32'h4000_0000);
    settle();
    chk("R10 write right after fourth byte", 32'(log_cyc[0]), 32'(done_cyc[0]));
    send_group(0, 32'h1234_5600);
    settle();
    chk("R2 R4 count", 32'(log_n), 2);
    chk_log("R2 R4 first", 0, 16'h0100, 24'h400000);
    chk_log("R2 R4 second", 1, 16'h0101, 24'h123456);
    chk("R9 no error on zero pad", 32'(lsb_err), 0);
  endtask

  task automatic t_partial();
    set_base(1, 16'h0200);
    log_n = 0;
    send_byte(1, 8'h77);
    send_byte(1, 8'h88);
    @(negedge clk); s_valid[1] = 0;
    set_base(1, 16'h0300);
    send_group(1, 32'hAABB_CC00);
    settle();
    chk("R3 partial discarded count", 32'(log_n), 1);
    chk_log("R3 restart at new base", 0, 16'h0300, 24'hAABBCC);
  endtask

  task automatic t_err();
    set_base(2, 16'h0050);
    log_n = 0;
    send_group(2, 32'h1122_3344);
    settle();
    chk("R8 flag set", 32'(lsb_err), 32'h4);
    send_group(2, 32'h5566_7700);
    settle();
    chk("R8 flag sticky", 32'(lsb_err), 32'h4);
    chk_log("R8 word still written", 0, 16'h0050, 24'h112233);
    chk_log("R4 R8 next", 1, 16'h0051, 24'h556677);
  endtask

  task automatic t_rr();
    set_base(0, 16'h1000);
    set_base(1, 16'h2000);
    set_base(2, 16'h3000);
    log_n = 0;
    fork
      send_group(0, 32'hA0A1_A200);
      send_group(1, 32'hB0B1_B200);
    join
    settle();
    chk("R6 round A count", 32'(log_n), 2);
    chk_log("R6 R5 A first ep0", 0, 16'h1000, 24'hA0A1A2);
    chk_log("R6 R5 A second ep1", 1, 16'h2000, 24'hB0B1B2);
    chk("R6 one write per cycle", 32'(log_cyc[1] - log_cyc[0]), 1);
    log_n = 0;
    fork
      send_group(0, 32'hC0C1_C200);
      send_group(1, 32'hD0D1_D200);
      send_group(2, 32'hE0E1_E200);
    join
    #1 chk("R7 all waiting not ready", 32'(s_ready), 0);
    @(negedge clk);
    #1 chk("R7 only granted ep2 ready", 32'(s_ready), 32'h4);
    settle();
    chk("R6 round B count", 32'(log_n), 3);
    chk_log("R6 R5 B first ep2", 0, 16'h3000, 24'hE0E1E2);
    chk_log("R6 R5 B second ep0", 1, 16'h1001, 24'hC0C1C2);
    chk_log("R6 R5 B third ep1", 2, 16'h2001, 24'hD0D1D2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pack();
    t_partial();
    t_err();
    t_rr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule